// File: doc/BRIEF.md
# ReLU and Dropout Mask Store for Fully Connected Training

This block sits behind a fully connected layer of a network that is trained on chip. In the forward pass it takes one layer output element at a time. The element comes with a sample index and a neuron index. The block applies ReLU, then applies a dropout decision, and returns the resulting value one cycle later. It also records a single bit for that sample and neuron. The bit is 1 when the element was forced to zero by either cause. Only the returned value needs to leave the chip. The bit array stays inside the block.

In the backward pass the same sample and neuron address is presented with a back-propagated error element. One cycle later the error comes back. It is zero if the stored bit is 1 and unchanged otherwise.

The dropout decision comes from a deterministic pseudo-random generator. An iteration counter, advanced by a pulse at each training iteration boundary, reseeds the generator every `period` iterations. As a result, the same dropout pattern is replayed with a programmable period.

A small control state machine names what the output stage holds in each cycle:
- `ST_IDLE` holds nothing.
- `ST_FWD` holds a forward result.
- `ST_BWD` holds a backward result.

From any state the machine moves as follows:
- It moves to `ST_FWD` when a forward request is accepted.
- Otherwise it moves to `ST_BWD` when a backward request is accepted.
- Otherwise it moves to `ST_IDLE`.

Top module: `relu_dropout_mask`

## Requirements
- R1: While reset is held, and in the first cycle after it, neither output valid is asserted. Reset clears every stored bit, loads the generator with seed 16'hACE1 and sets the iteration count to 0. The first forward element after reset therefore sees the drop bit of the seed, which is 1.
- R2: A forward element whose most significant bit is 1 (negative in two's complement) is returned one cycle after `fwd_valid` as zero, with `fwd_out_mask` = 1.
- R3: A forward element that is non-negative and not dropped is returned one cycle later unchanged, with `fwd_out_mask` = 0. An input of zero is returned as zero with mask 0.
- R4: Dropout uses a 16-bit Galois generator. Each step shifts the state right by one bit; if the bit shifted out was 1, the new state is XORed with 16'hB400. The drop bit is bit 0 of the current state. An element is dropped (output zero, mask 1) when `drop_en` = 1 and the drop bit is 1. With `drop_en` = 0 nothing is dropped. The generator steps once for every accepted forward element, whatever the value of `drop_en`.
- R5: Each `iter_start` pulse ends an iteration. If the count equals `period`-1, or `period` is 0 or 1, the pulse reloads the seed and clears the count. Otherwise it increments the count and leaves the generator state alone. For equal forward traffic, iteration k and iteration k+`period` produce identical masks.
- R6: The mask bit of a forward element is stored at sample*NEURONS+neuron. A later forward element to the same address overwrites it.
- R7: A backward request returns `bwd_out_err` one cycle later. The value is zero when the stored bit is 1 and equal to `bwd_err` when it is 0.
- R8: When `fwd_valid` and `bwd_valid` are both high, only the forward element is accepted. No backward result is produced for that cycle.
- R9: Each accepted request yields exactly one output valid cycle of its kind. `fwd_out_valid` and `bwd_out_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drop_en | input | 1 | Enables dropout on forward elements |
| period | input | 6 | Dropout pattern period in iterations |
| iter_start | input | 1 | Pulse marking a training iteration boundary |
| sample_idx | input | 4 | Sample index shared by both directions |
| neuron_idx | input | 6 | Neuron index shared by both directions |
| fwd_valid | input | 1 | Forward element request |
| fwd_data | input | 16 | Signed layer output element |
| bwd_valid | input | 1 | Backward element request |
| bwd_err | input | 16 | Back-propagated error element |
| fwd_out_valid | output | 1 | Forward result valid |
| fwd_out_data | output | 16 | Value after ReLU and dropout |
| fwd_out_mask | output | 1 | 1 when the element was zeroed |
| bwd_out_valid | output | 1 | Backward result valid |
| bwd_out_err | output | 16 | Error after masking |

## Verification
The block's errors surface at the ports in three ways:
- A wrong bit in the array stays hidden until the backward request for that address. It then shows as an error that is zeroed or passed when it should not be, one cycle after the request.
- A generator that steps too often, skips a reseed, or reseeds late corrupts the drop decisions at once. It stays wrong for every later element until the next reseed, so comparing whole iterations exposes it within one period.
- A control state that records the wrong kind of request shows as a missing or extra valid cycle. This appears one cycle after the request, and an expected-result queue catches it.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_BWD  = 2'd2
    } rdm_state_e;

    localparam int unsigned RDM_LFSR_W = 16;
    localparam logic [RDM_LFSR_W-1:0] RDM_TAPS = 16'hB400;
    localparam logic [RDM_LFSR_W-1:0] RDM_SEED = 16'hACE1;

endpackage

// File: rtl/rdm_pattern_gen.sv
module rdm_pattern_gen #(
    parameter int unsigned LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
    parameter int unsigned PERIOD_W  = 6,
    parameter int unsigned DROP_BITS = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iter_start,
    input  logic [PERIOD_W-1:0] period,
    input  logic                step,
    output logic                drop_bit
);

    logic [LFSR_W-1:0]   lfsr_q;
    logic [LFSR_W-1:0]   lfsr_next;
    logic [PERIOD_W-1:0] iter_q;
    logic                wrap;

    // Last iteration of the period: reseed on the next boundary pulse.
    always_comb begin
        wrap = (period <= PERIOD_W'(1)) || (iter_q >= (period - PERIOD_W'(1)));
    end

    always_comb begin
        lfsr_next = {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
            iter_q <= '0;
        end else begin
            if (iter_start && wrap) begin
                lfsr_q <= SEED;
            end else if (step) begin
                lfsr_q <= lfsr_next;
            end
            if (iter_start) begin
                iter_q <= wrap ? '0 : iter_q + PERIOD_W'(1);
            end
        end
    end

    assign drop_bit = &lfsr_q[DROP_BITS-1:0];

    assert_reseed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_start && wrap) |=> (lfsr_q == SEED && iter_q == '0))
        else $error("reseed did not happen at period wrap");

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!iter_start && !step) |=> $stable(lfsr_q))
        else $error("generator moved without a forward element");

    assert_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0)
        else $error("generator reached the all-zero lock state");

endmodule

// File: rtl/rdm_mask_array.sv
module rdm_mask_array #(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    logic [DEPTH-1:0] bits_q;
    logic             rd_bit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q[wr_addr] <= wr_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bit_q <= 1'b0;
        end else if (rd_en) begin
            rd_bit_q <= bits_q[rd_addr];
        end
    end

    assign rd_bit = rd_bit_q;

    assert_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bits_q[$past(wr_addr)] == $past(wr_bit)))
        else $error("mask bit not stored at its address");

endmodule

// File: rtl/rdm_zero_gate.sv
module rdm_zero_gate #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] din,
    input  logic         kill,
    output logic [W-1:0] dout
);

    always_comb begin
        dout = kill ? '0 : din;
    end

endmodule

// File: rtl/relu_dropout_mask.sv
module relu_dropout_mask
    import rdm_pkg::*;
#(
    parameter int unsigned SAMPLES   = 16,
    parameter int unsigned NEURONS   = 64,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned PERIOD_W  = 6,
    parameter int unsigned DROP_BITS = 1,
    localparam int unsigned SAW      = $clog2(SAMPLES),
    localparam int unsigned NAW      = $clog2(NEURONS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                drop_en,
    input  logic [PERIOD_W-1:0] period,
    input  logic                iter_start,
    input  logic [SAW-1:0]      sample_idx,
    input  logic [NAW-1:0]      neuron_idx,
    input  logic                fwd_valid,
    input  logic [DATA_W-1:0]   fwd_data,
    input  logic                bwd_valid,
    input  logic [DATA_W-1:0]   bwd_err,
    output logic                fwd_out_valid,
    output logic [DATA_W-1:0]   fwd_out_data,
    output logic                fwd_out_mask,
    output logic                bwd_out_valid,
    output logic [DATA_W-1:0]   bwd_out_err
);

    localparam int unsigned DEPTH = SAMPLES * NEURONS;
    localparam int unsigned AW    = $clog2(DEPTH);

    rdm_state_e        st_q, st_d;
    logic [AW-1:0]     flat_addr;
    logic              fwd_take, bwd_take;
    logic              drop_bit;
    logic              relu_kill, drop_kill, fwd_kill;
    logic [DATA_W-1:0] fwd_gated;
    logic [DATA_W-1:0] fwd_data_q;
    logic              fwd_mask_q;
    logic [DATA_W-1:0] bwd_err_q;
    logic              stored_bit;
    logic [DATA_W-1:0] bwd_gated;

    always_comb begin
        flat_addr = AW'(32'(sample_idx) * NEURONS + 32'(neuron_idx));
        fwd_take  = fwd_valid;
        bwd_take  = bwd_valid && !fwd_valid;
        relu_kill = fwd_data[DATA_W-1];
        drop_kill = drop_en && drop_bit;
        fwd_kill  = relu_kill || drop_kill;
    end

    rdm_pattern_gen #(
        .LFSR_W    (RDM_LFSR_W),
        .TAPS      (RDM_TAPS),
        .SEED      (RDM_SEED),
        .PERIOD_W  (PERIOD_W),
        .DROP_BITS (DROP_BITS)
    ) u_pattern (
        .clk        (clk),
        .rst_n      (rst_n),
        .iter_start (iter_start),
        .period     (period),
        .step       (fwd_take),
        .drop_bit   (drop_bit)
    );

    rdm_mask_array #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fwd_take),
        .wr_addr (flat_addr),
        .wr_bit  (fwd_kill),
        .rd_en   (bwd_take),
        .rd_addr (flat_addr),
        .rd_bit  (stored_bit)
    );

    rdm_zero_gate #(.W(DATA_W)) u_fwd_gate (
        .din  (fwd_data),
        .kill (fwd_kill),
        .dout (fwd_gated)
    );

    rdm_zero_gate #(.W(DATA_W)) u_bwd_gate (
        .din  (bwd_err_q),
        .kill (stored_bit),
        .dout (bwd_gated)
    );

    // Next-state selection: forward wins a collision.
    always_comb begin
        if (fwd_take) begin
            st_d = ST_FWD;
        end else if (bwd_take) begin
            st_d = ST_BWD;
        end else begin
            st_d = ST_IDLE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Payload registers for the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_data_q <= '0;
            fwd_mask_q <= 1'b0;
            bwd_err_q  <= '0;
        end else begin
            if (fwd_take) begin
                fwd_data_q <= fwd_gated;
                fwd_mask_q <= fwd_kill;
            end
            if (bwd_take) begin
                bwd_err_q <= bwd_err;
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        fwd_out_valid = 1'b0;
        fwd_out_data  = '0;
        fwd_out_mask  = 1'b0;
        bwd_out_valid = 1'b0;
        bwd_out_err   = '0;
        unique case (st_q)
            ST_IDLE: begin
            end
            ST_FWD: begin
                fwd_out_valid = 1'b1;
                fwd_out_data  = fwd_data_q;
                fwd_out_mask  = fwd_mask_q;
            end
            ST_BWD: begin
                bwd_out_valid = 1'b1;
                bwd_out_err   = bwd_gated;
            end
            default: begin
            end
        endcase
    end

    assert_relu_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_data[DATA_W-1]) |=>
        (fwd_out_valid && fwd_out_mask && fwd_out_data == '0))
        else $error("negative element not zeroed");

    assert_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_data[DATA_W-1] && !(drop_en && drop_bit)) |=>
        (fwd_out_valid && !fwd_out_mask && fwd_out_data == $past(fwd_data)))
        else $error("kept element altered");

    assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && drop_en && drop_bit) |=>
        (fwd_out_mask && fwd_out_data == '0))
        else $error("dropped element not zeroed");

    assert_bwd_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bwd_valid && !fwd_valid) |=> bwd_out_valid)
        else $error("backward result missing");

    assert_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && bwd_valid) |=> (fwd_out_valid && !bwd_out_valid))
        else $error("collision not resolved toward forward");

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_out_valid && bwd_out_valid))
        else $error("both output valids high");

endmodule

// File: tb/relu_dropout_mask_bench.sv
module relu_dropout_mask_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        drop_en;
    logic [5:0]  period;
    logic        iter_start;
    logic [3:0]  sample_idx;
    logic [5:0]  neuron_idx;
    logic        fwd_valid;
    logic [15:0] fwd_data;
    logic        bwd_valid;
    logic [15:0] bwd_err;
    logic        fwd_out_valid;
    logic [15:0] fwd_out_data;
    logic        fwd_out_mask;
    logic        bwd_out_valid;
    logic [15:0] bwd_out_err;

    always #10 clk = ~clk;

    relu_dropout_mask u_relu_dropout_mask (
        .clk           (clk),
        .rst_n         (rst_n),
        .drop_en       (drop_en),
        .period        (period),
        .iter_start    (iter_start),
        .sample_idx    (sample_idx),
        .neuron_idx    (neuron_idx),
        .fwd_valid     (fwd_valid),
        .fwd_data      (fwd_data),
        .bwd_valid     (bwd_valid),
        .bwd_err       (bwd_err),
        .fwd_out_valid (fwd_out_valid),
        .fwd_out_data  (fwd_out_data),
        .fwd_out_mask  (fwd_out_mask),
        .bwd_out_valid (bwd_out_valid),
        .bwd_out_err   (bwd_out_err)
    );

    typedef struct {
        bit          is_fwd;
        logic [15:0] val;
        bit          mask;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    bit          mask_log[$];
    int          n_checks = 0;
    int          n_fail = 0;
    logic [15:0] m_lfsr;
    int          m_iter;
    bit          m_mem [0:1023];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lfsr = 16'hACE1;
        m_iter = 0;
        for (int i = 0; i < 1024; i++) m_mem[i] = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Driver tasks: called right after a falling edge.
    task automatic do_fwd(input int s, input int n, input logic [15:0] d, input string req);
        exp_t e;
        bit   drop;
        drop = drop_en && m_lfsr[0];
        e.is_fwd = 1'b1;
        e.mask   = d[15] || drop;
        e.val    = e.mask ? 16'h0 : d;
        e.req    = req;
        sb_q.push_back(e);
        m_mem[s * 64 + n] = e.mask;
        m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0);
        sample_idx = 4'(s);
        neuron_idx = 6'(n);
        fwd_data   = d;
        fwd_valid  = 1'b1;
        @(negedge clk);
        fwd_valid  = 1'b0;
    endtask

    task automatic do_bwd(input int s, input int n, input logic [15:0] err, input string req);
        exp_t e;
        e.is_fwd = 1'b0;
        e.mask   = m_mem[s * 64 + n];
        e.val    = e.mask ? 16'h0 : err;
        e.req    = req;
        sb_q.push_back(e);
        sample_idx = 4'(s);
        neuron_idx = 6'(n);
        bwd_err    = err;
        bwd_valid  = 1'b1;
        @(negedge clk);
        bwd_valid  = 1'b0;
    endtask

    task automatic do_both(input int s, input int n, input logic [15:0] d, input logic [15:0] err);
        bwd_err   = err;
        bwd_valid = 1'b1;
        do_fwd(s, n, d, "R8");
        bwd_valid = 1'b0;
    endtask

    task automatic do_iter();
        if (period <= 6'd1 || m_iter >= int'(period) - 1) begin
            m_iter = 0;
            m_lfsr = 16'hACE1;
        end else begin
            m_iter++;
        end
        iter_start = 1'b1;
        @(negedge clk);
        iter_start = 1'b0;
    endtask

    task automatic run_iters(input int count);
        for (int k = 0; k < count; k++) begin
            for (int j = 0; j < 8; j++) do_fwd(2, j, 16'(50 + j), "R4");
            if (k != count - 1) do_iter();
        end
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compares results against the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fwd_out_valid && bwd_out_valid)
                chk(1'b0, "R9", "both valids", 1, 0);
            else if (fwd_out_valid || bwd_out_valid) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (fwd_out_valid) mask_log.push_back(fwd_out_mask);
                    chk(fwd_out_valid == e.is_fwd, e.req, "result kind",
                        int'(fwd_out_valid), int'(e.is_fwd));
                    if (e.is_fwd) begin
                        chk(fwd_out_data == e.val, e.req, "fwd data",
                            int'(fwd_out_data), int'(e.val));
                        chk(fwd_out_mask == e.mask, e.req, "fwd mask",
                            int'(fwd_out_mask), int'(e.mask));
                    end else begin
                        chk(bwd_out_err == e.val, e.req, "bwd err",
                            int'(bwd_out_err), int'(e.val));
                    end
                end
            end
        end
    end

    task automatic report();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        rst_n = 1'b0; drop_en = 1'b0; period = 6'd3; iter_start = 1'b0;
        sample_idx = '0; neuron_idx = '0; fwd_valid = 1'b0; fwd_data = '0;
        bwd_valid = 1'b0; bwd_err = '0;
        model_reset();
        repeat (3) @(negedge clk);
        chk(!fwd_out_valid && !bwd_out_valid, "R1", "valids in reset",
            int'(fwd_out_valid | bwd_out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!fwd_out_valid && !bwd_out_valid, "R1", "valids after reset",
            int'(fwd_out_valid | bwd_out_valid), 0);

        // ReLU only
        do_fwd(0, 0, 16'd100,   "R3");
        do_fwd(0, 1, -16'sd5,   "R2");
        do_fwd(0, 2, 16'd0,     "R3");
        do_fwd(0, 3, 16'h7FFF,  "R3");
        do_fwd(0, 4, 16'h8000,  "R2");
        do_bwd(0, 0, 16'h0123, "R7");
        do_bwd(0, 1, 16'h0456, "R7");
        do_bwd(0, 2, 16'h0789, "R7");
        do_bwd(0, 3, 16'hFFFF, "R7");
        do_bwd(0, 4, 16'h1111, "R7");
        // overwrite a zeroed entry
        do_fwd(0, 1, 16'd7, "R6");
        do_bwd(0, 1, 16'h2222, "R6");
        // collision, then read what the forward wrote
        do_both(1, 0, -16'sd3, 16'd55);
        do_bwd(1, 0, 16'd9, "R8");
        repeat (4) @(negedge clk);

        // Dropout, period 3, from a fresh seed
        do_reset();
        drop_en = 1'b1; period = 6'd3;
        mask_log.delete();
        run_iters(7);
        chk(mask_log.size() == 56, "R5", "logged elements", mask_log.size(), 56);
        if (mask_log.size() == 56) begin
            chk(mask_log[0] == 1'b1, "R1", "first drop bit from seed", int'(mask_log[0]), 1);
            for (int k = 0; k < 4; k++) begin
                for (int j = 0; j < 8; j++) begin
                    chk(mask_log[k*8+j] == mask_log[(k+3)*8+j], "R5", "pattern repeat",
                        int'(mask_log[(k+3)*8+j]), int'(mask_log[k*8+j]));
                end
            end
        end
        for (int j = 0; j < 8; j++) do_bwd(2, j, 16'(1000 + j), "R7");

        // Period 1: every iteration restarts
        period = 6'd1;
        do_iter();
        mask_log.delete();
        run_iters(3);
        if (mask_log.size() == 24) begin
            for (int j = 0; j < 16; j++)
                chk(mask_log[j] == mask_log[j+8], "R5", "period 1 repeat",
                    int'(mask_log[j+8]), int'(mask_log[j]));
        end else begin
            chk(1'b0, "R5", "period 1 log size", mask_log.size(), 24);
        end

        // Generator keeps stepping with dropout off
        drop_en = 1'b0;
        for (int j = 0; j < 5; j++) do_fwd(3, j, 16'(10 + j), "R4");
        drop_en = 1'b1;
        for (int j = 5; j < 13; j++) do_fwd(3, j, 16'(10 + j), "R4");
        for (int j = 0; j < 13; j++) do_bwd(3, j, 16'h0ABC, "R7");

        repeat (5) @(negedge clk);
        chk(sb_q.size() == 0, "R9", "results outstanding", sb_q.size(), 0);
        report();
    end

endmodule